// File: doc/BRIEF.md
# Standby Resume Reset Sequencer

This block decides when the resume reset of a standby power domain may be released. The output `rsm_rel` is active high: high means the standby logic may leave reset. The output rises only after the 3.3 V standby input and the standby power-good indication have both stayed true for a programmable debounce interval. The interval is counted on a free-running 1 ms tick that arrives on `tick_1ms`.

Software can remove the power-good condition from the release check with a bypass bit. Two active-low external control requests can each pull the output low when their own enable bit is set. A sticky AC-loss flag records every falling edge of standby power-good, and software clears it by writing 1 to it.

The configuration bits and the flag belong to a battery-backed domain that `bat_rst_n` resets. The sequencer itself belongs to the standby domain that `rst_n` resets. A loss of standby power therefore leaves the configuration bits and the flag as they were. Register access uses a plain write strobe and a combinational read port. No part of the block streams data, so every pin is a plain level or strobe.

Top module: `rsm_rst_seq`

## Requirements
- R1: `rsm_rel` rises only after `sb33_in` and `sb_pgood` have both been continuously high for N+1 rising `tick_1ms` pulses, where N is the debounce register. If either input goes low, `rsm_rel` is low from the next clock cycle.
- R2: When the bypass bit (control register bit 2) is 1, `sb_pgood` has no effect on `rsm_rel`, and `sb33_in` alone gates the release.
- R3: Control register bit 0 enables request 0 and bit 1 enables request 1, and both reset to 0. While a request's enable is set, driving that request's `ctl_req_n` bit low drives `rsm_rel` low in the next cycle. While the enable is clear, the request has no effect.
- R4: Any interruption of the gating conditions, including an enabled force request, restarts the debounce count from zero. The full N+1 ticks must then elapse again before release.
- R5: The debounce register (address 1) resets to 09h, which gives 10 ticks. A write to it takes effect only for a count whose first tick comes after the write.
- R6: The AC-loss flag (control register bit 7) is set one cycle after a falling edge of `sb_pgood`. Writing 1 to bit 7 clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: `rst_n` holds `rsm_rel` low and clears the count. The configuration bits, the debounce register and the AC-loss flag are reset only by `bat_rst_n`.
- R8: Reading address 0 returns {flag, 4'b0, bypass, en1, en0}. Reading address 1 returns the debounce register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst_n | input | 1 | Active-low standby-domain reset |
| bat_rst_n | input | 1 | Active-low battery-domain reset for the configuration bits and the flag |
| tick_1ms | input | 1 | One-cycle pulse every 1 ms |
| sb_pgood | input | 1 | Standby rail power-good |
| sb33_in | input | 1 | 3.3 V standby input level |
| ctl_req_n | input | 2 | Active-low external force-low requests |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 debounce) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data, combinational |
| rsm_rel | output | 1 | Resume reset release, active high |

## Verification
The bench counts ticks exactly at the release boundary. A count that is off by one would release on tick N or on tick N+2. Glitches placed in the middle of a count show whether the count restarts or resumes. A design that resumes would release too early. The bench rewrites the debounce value partway through a count, so a design that applies the new value at once would release at the wrong tick. It also lines up a write-1 clear with a power-good fall in the same cycle, where a design that lets the clear win would lose the loss event. Finally, it pulses the standby reset alone, which catches a design that wipes battery-domain state on that reset.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_REQ    = 2;
  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_DEB = 1'b1;
  localparam int BIT_BYPASS = 2;
  localparam int BIT_ACLOST = 7;
  localparam logic [DATA_W-1:0] DEB_RESET = 8'h09;

  typedef struct packed {
    logic [NUM_REQ-1:0] en;
    logic               bypass;
  } ctl_t;
endpackage

// File: rtl/rsm_cfg_regs.sv
module rsm_cfg_regs
  import rsm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_REQ
) (
  input  logic          clk,
  input  logic          bat_rst_n,
  input  logic          sb_pgood,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [NR-1:0] en,
  output logic          bypass,
  output logic [DW-1:0] deb_val,
  output logic          ac_lost,
  output logic          pg_prev
);
  localparam int PAD_W = BIT_ACLOST - BIT_BYPASS - 1;

  logic wr_ctl, wr_deb, ac_set, ac_clr;

  assign wr_ctl = wr_en && (wr_addr == ADDR_CTL);
  assign wr_deb = wr_en && (wr_addr == ADDR_DEB);
  assign ac_set = pg_prev && !sb_pgood;
  assign ac_clr = wr_ctl && wr_data[BIT_ACLOST];

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) begin
      en      <= '0;
      bypass  <= 1'b0;
      deb_val <= DEB_RESET;
      ac_lost <= 1'b0;
      pg_prev <= 1'b0;
    end else begin
      pg_prev <= sb_pgood;
      if (wr_ctl) begin
        en     <= wr_data[NR-1:0];
        bypass <= wr_data[BIT_BYPASS];
      end
      if (wr_deb) deb_val <= wr_data;
      if (ac_set)      ac_lost <= 1'b1;
      else if (ac_clr) ac_lost <= 1'b0;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_DEB) rd_data = deb_val;
    else rd_data = {ac_lost, {PAD_W{1'b0}}, bypass, en};
  end
endmodule

// File: rtl/rsm_gate.sv
module rsm_gate #(
  parameter int NR = 2
) (
  input  logic          sb_pgood,
  input  logic          sb33_in,
  input  logic          bypass,
  input  logic [NR-1:0] en,
  input  logic [NR-1:0] req_n,
  output logic          ok
);
  logic [NR-1:0] force_vec;
  logic          power_ok;

  for (genvar i = 0; i < NR; i++) begin : g_req
    assign force_vec[i] = en[i] && !req_n[i];
  end

  assign power_ok = sb33_in && (bypass || sb_pgood);
  assign ok       = power_ok && (force_vec == '0);
endmodule

// File: rtl/rsm_debounce.sv
module rsm_debounce #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ok,
  input  logic          tick,
  input  logic [DW-1:0] deb_val,
  output logic          rel
);
  logic [DW-1:0] cnt_q, lim_q, lim_eff;
  logic          idle;

  assign idle    = (cnt_q == '0) && !rel;
  assign lim_eff = idle ? deb_val : lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      rel   <= 1'b0;
    end else begin
      if (idle) lim_q <= deb_val;
      if (!ok) begin
        cnt_q <= '0;
        rel   <= 1'b0;
      end else if (!rel && tick) begin
        if (cnt_q == lim_eff) begin
          cnt_q <= '0;
          rel   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsm_rst_seq.sv
module rsm_rst_seq
  import rsm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_REQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bat_rst_n,
  input  logic          tick_1ms,
  input  logic          sb_pgood,
  input  logic          sb33_in,
  input  logic [NR-1:0] ctl_req_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rsm_rel
);
  logic [NR-1:0] en_q;
  logic          bypass_q, ac_lost_q, pg_prev_q, ok;
  logic [DW-1:0] deb_q;

  rsm_cfg_regs #(.DW(DW), .NR(NR)) u_cfg (
    .clk(clk), .bat_rst_n(bat_rst_n), .sb_pgood(sb_pgood),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .en(en_q), .bypass(bypass_q), .deb_val(deb_q),
    .ac_lost(ac_lost_q), .pg_prev(pg_prev_q)
  );

  rsm_gate #(.NR(NR)) u_gate (
    .sb_pgood(sb_pgood), .sb33_in(sb33_in), .bypass(bypass_q),
    .en(en_q), .req_n(ctl_req_n), .ok(ok)
  );

  rsm_debounce #(.DW(DW)) u_deb (
    .clk(clk), .rst_n(rst_n), .ok(ok), .tick(tick_1ms),
    .deb_val(deb_q), .rel(rsm_rel)
  );
endmodule

// File: rtl/rsm_rst_seq_chk.sv
module rsm_rst_seq_chk #(
  parameter int NR = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bat_rst_n,
  input logic          tick_1ms,
  input logic          sb_pgood,
  input logic          sb33_in,
  input logic [NR-1:0] ctl_req_n,
  input logic [NR-1:0] en_q,
  input logic          bypass_q,
  input logic          ac_lost_q,
  input logic          pg_prev_q,
  input logic          rsm_rel
);
  p_sb33_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sb33_in |=> !rsm_rel);

  p_pgood_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sb_pgood && !bypass_q) |=> !rsm_rel);

  p_force0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[0] && !ctl_req_n[0]) |=> !rsm_rel);

  p_force1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[1] && !ctl_req_n[1]) |=> !rsm_rel);

  p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsm_rel) |-> $past(tick_1ms));

  p_ac_set_r6: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (pg_prev_q && !sb_pgood) |=> ac_lost_q);

  always_comb begin
    if (!rst_n) p_hold_low_r7: assert (!rsm_rel);
  end
endmodule

bind rsm_rst_seq rsm_rst_seq_chk #(.NR(NR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bat_rst_n(bat_rst_n), .tick_1ms(tick_1ms),
  .sb_pgood(sb_pgood), .sb33_in(sb33_in), .ctl_req_n(ctl_req_n),
  .en_q(en_q), .bypass_q(bypass_q), .ac_lost_q(ac_lost_q),
  .pg_prev_q(pg_prev_q), .rsm_rel(rsm_rel)
);

// File: tb/sim_rsm_rst_seq.sv
`timescale 1ns/1ps
module sim_rsm_rst_seq;
  logic       clk = 1'b0;
  logic       rst_n, bat_rst_n, tick_1ms, sb_pgood, sb33_in;
  logic [1:0] ctl_req_n;
  logic       wr_en, wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       rsm_rel;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rsm_rst_seq u0 (
    .clk(clk), .rst_n(rst_n), .bat_rst_n(bat_rst_n), .tick_1ms(tick_1ms),
    .sb_pgood(sb_pgood), .sb33_in(sb33_in), .ctl_req_n(ctl_req_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rsm_rel(rsm_rel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
    cyc(2);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // n ticks keep the output low, tick n+1 releases it
  task automatic expect_release(input string req, input int n);
    ticks(n);
    chk(req, rsm_rel, 1'b0);
    tick();
    chk(req, rsm_rel, 1'b1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 reset low", rsm_rel, 1'b0);
    rd(1'b1, d); chk("R5 deb reset 09h", d, 8'h09);
    rd(1'b0, d); chk("R8 ctl reset 0", d, 8'h00);
  endtask

  task automatic t_basic();
    sb_pgood = 1'b1; sb33_in = 1'b1;
    cyc(1);
    expect_release("R1 basic 10 ticks", 9);
  endtask

  task automatic t_restart();
    sb33_in = 1'b0; cyc(1);
    chk("R1 drop low next cycle", rsm_rel, 1'b0);
    sb33_in = 1'b1; ticks(5);
    sb33_in = 1'b0; cyc(1); sb33_in = 1'b1;
    expect_release("R4 restart after glitch", 9);
  endtask

  task automatic t_bypass();
    logic [7:0] d;
    wr(1'b0, 8'h04);
    rd(1'b0, d); chk("R8 bypass readback", d, 8'h04);
    sb_pgood = 1'b0; cyc(2);
    chk("R2 pgood ignored", rsm_rel, 1'b1);
    wr(1'b0, 8'h00); cyc(1);
    chk("R1 pgood gates again", rsm_rel, 1'b0);
    rd(1'b0, d); chk("R6 flag set on pgood fall", d, 8'h80);
    wr(1'b0, 8'h80);
    rd(1'b0, d); chk("R6 w1c clears", d, 8'h00);
    sb_pgood = 1'b1; cyc(1);
    expect_release("R1 re-release", 9);
  endtask

  task automatic t_force();
    ctl_req_n = 2'b10; cyc(1); tick();
    chk("R3 disabled req0 no effect", rsm_rel, 1'b1);
    wr(1'b0, 8'h01); cyc(1);
    chk("R3 enabled req0 forces low", rsm_rel, 1'b0);
    ctl_req_n = 2'b11; cyc(1);
    expect_release("R4 full interval after req0", 9);
    ctl_req_n = 2'b01; cyc(1); tick();
    chk("R3 disabled req1 no effect", rsm_rel, 1'b1);
    wr(1'b0, 8'h03); cyc(1);
    chk("R3 enabled req1 forces low", rsm_rel, 1'b0);
    ctl_req_n = 2'b11; cyc(1);
    expect_release("R4 full interval after req1", 9);
  endtask

  task automatic t_deb_change();
    sb33_in = 1'b0; cyc(1);
    wr(1'b1, 8'h03);
    sb33_in = 1'b1; cyc(1);
    expect_release("R5 new value 4 ticks", 3);
    sb33_in = 1'b0; cyc(1); sb33_in = 1'b1; cyc(1);
    tick();
    wr(1'b1, 8'h05);
    expect_release("R5 mid-count write deferred", 2);
    sb33_in = 1'b0; cyc(1); sb33_in = 1'b1; cyc(1);
    expect_release("R5 next count uses 6 ticks", 5);
  endtask

  task automatic t_acloss();
    logic [7:0] d;
    sb_pgood = 1'b0;
    wr(1'b0, 8'h80);
    cyc(1);
    rd(1'b0, d); chk("R6 set wins over clear", d, 8'h80);
    rst_n = 1'b0; cyc(2);
    chk("R7 held low in reset", rsm_rel, 1'b0);
    rst_n = 1'b1; cyc(1);
    rd(1'b0, d); chk("R7 flag kept over rst_n", d, 8'h80);
    rd(1'b1, d); chk("R7 deb kept over rst_n", d, 8'h05);
    sb_pgood = 1'b1; cyc(1);
    expect_release("R7 count after rst_n", 5);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bat_rst_n = 0; tick_1ms = 0; sb_pgood = 0; sb33_in = 0;
    ctl_req_n = 2'b11; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    cyc(3);
    bat_rst_n = 1; rst_n = 1;
    cyc(1);
    t_reset();
    t_basic();
    t_restart();
    t_bypass();
    t_force();
    t_deb_change();
    t_acloss();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule